// File: doc/BRIEF.md
# NAND flash bus interface controller

This block lets a processor drive a raw 8-bit NAND flash bus through a small 32-bit register window. Software sets the flash control lines (chip enable, command latch, address latch, chip select) through a mode register. Each access to the data register then runs one timed strobe cycle on the flash pins. A write of the data register, allowed only while the write-enable mode bit is set, drives a byte onto DQ and pulses WE#. A read of the data register pulses RE# and returns the byte sampled from DQ. Command and address cycles are data writes made with CLE or ALE raised in the mode register.

The active part of the strobe lasts SPW+1 clocks and the hold that follows lasts HOLD+2 clocks. Both counts come from one packed timing register. The flash ready/busy line is synchronised and reported in a status register. A self-clearing soft reset returns the mode and timing registers to their reset values. A processor access that arrives while a strobe cycle or a soft reset is running is stalled with a ready signal and is never dropped.

Top module: `nfc_bus_ctrl`

## Requirements
- R1: After hardware reset, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale, nand_dq_oe and nand_cs are 0, the mode register (byte offset 0x04) reads 0, the timing register (0x14) reads 0x23, and the status (0x08) and reset (0x18) registers read 0.
- R2: The mode register keeps bits 7 (write enable), 4 (chip enable), 3:2 (chip select), 1 (address latch) and 0 (command latch), and reads back the written value ANDed with 0x9F. From the clock edge that accepts the write, nand_ce_n is the inverse of bit 4, nand_ale equals bit 1, nand_cle equals bit 0, and nand_cs equals bits 3:2.
- R3: A write to the data register (0x00) while mode bit 7 is 1 completes at once. It then holds nand_we_n low for SPW+1 clocks and drives the low 8 bits of the written word on nand_dq_out, with nand_dq_oe high, for SPW+HOLD+3 clocks in total.
- R4: A write to the data register while mode bit 7 is 0 completes at once and produces no strobe and no DQ drive.
- R5: A read of the data register holds nand_re_n low for SPW+1 clocks with nand_dq_oe low. It completes after SPW+HOLD+4 wait cycles and returns the nand_dq_in byte in bits 7:0, with the upper bits 0.
- R6: Any access issued in the cycle after a data write is accepted waits SPW+HOLD+3 cycles, then completes normally.
- R7: The timing register holds HOLD in bits 7:4 and SPW in bits 3:0, and reads back the written low byte.
- R8: Status bit 7 reads 1 while nand_rb_n is 0. The value passes through two flip-flops, so a change is seen by a read issued two clock edges after it and not by a read issued one edge after it.
- R9: Writing 1 to bit 0 of the reset register makes that bit read 1 for the three cycles after the write and 0 afterwards. It clears the mode register to 0 and sets the timing register to 0x23. Accesses to other registers stall while the bit is 1. Writing 0 has no effect.
- R10: The byte offsets 0x0C, 0x10 and 0x1C read 0, and writes to them change no register.
- R11: WE# and RE# are never low together, and the chip enable, command latch, address latch and chip-select pins do not change while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cs | output | 2 | Chip-select field |
| nand_dq_out | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | DQ output enable |
| nand_dq_in | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Flash ready/busy, low when busy |

## Verification
The hardest case to reach is an access that collides with a cycle already running on the flash pins, because the processor side only sees the stall length. The stimulus sweeps all 256 pairs of strobe width and hold. For each pair it issues a data write and then a status read in the very next cycle, and compares the read's wait count with the sum the timing predicts. A pin monitor counts the WE# low cycles and the DQ drive cycles over the same span. Reads get the same sweep with a different byte on DQ for each pair. The soft-reset window is tested by polling the reset bit and by stalling a mode read behind it.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
    localparam int REG_IDX_W = 3;
    localparam int ADDR_W    = REG_IDX_W + 2;

    localparam logic [REG_IDX_W-1:0] IDX_DATA = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_MODE = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_STAT = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_TIME = 3'd5;
    localparam logic [REG_IDX_W-1:0] IDX_RST  = 3'd6;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic       wen;
        logic       ce;
        logic [1:0] cs;
        logic       ale;
        logic       cle;
    } mode_t;
endpackage

// File: rtl/nfc_rb_sync.sv
`timescale 1ns/1ps
module nfc_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_strobe_engine.sv
`timescale 1ns/1ps
module nfc_strobe_engine
    import nfc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int DQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_read,
    input  logic [DQ_W-1:0]  wbyte,
    input  logic [CNT_W-1:0] spw,
    input  logic [CNT_W-1:0] hold,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             busy,
    output logic             we_n,
    output logic             re_n,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe,
    output logic [DQ_W-1:0]  rd_byte
);
    localparam int CW = CNT_W + 1;

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
        logic            rd;
        logic [DQ_W-1:0] dq;
        logic [DQ_W-1:0] cap;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_STROBE;
                    st_d.cnt   = {1'b0, spw};
                    st_d.rd    = is_read;
                    st_d.dq    = wbyte;
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = {1'b0, hold} + CW'(1);
                    if (st_q.rd) st_d.cap = dq_in;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) st_d.phase = PH_IDLE;
                else                st_d.cnt   = st_q.cnt - CW'(1);
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.rd    <= 1'b0;
            st_q.dq    <= '0;
            st_q.cap   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase != PH_IDLE);
    assign we_n    = !((st_q.phase == PH_STROBE) && !st_q.rd);
    assign re_n    = !((st_q.phase == PH_STROBE) && st_q.rd);
    assign dq_oe   = busy && !st_q.rd;
    assign dq_out  = st_q.dq;
    assign rd_byte = st_q.cap;
endmodule

// File: rtl/nfc_regfile.sv
`timescale 1ns/1ps
module nfc_regfile
    import nfc_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter int              DQ_W       = 8,
    parameter int              CNT_W      = 4,
    parameter int              RST_CYCLES = 3,
    parameter logic [CNT_W-1:0] DEF_SPW   = 4'd3,
    parameter logic [CNT_W-1:0] DEF_HOLD  = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    input  logic              eng_busy,
    input  logic [DQ_W-1:0]   rd_byte,
    input  logic              flash_busy,
    output logic              eng_start,
    output logic              eng_read,
    output logic [DQ_W-1:0]   eng_byte,
    output mode_t             mode,
    output logic [CNT_W-1:0]  spw,
    output logic [CNT_W-1:0]  hold,
    output logic              rst_active
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] spw;
        logic [CNT_W-1:0] hold;
        logic             rst_act;
        logic [RC_W-1:0]  rst_cnt;
        logic             rd_pend;
    } regs_t;

    regs_t r_d, r_q;
    logic [REG_IDX_W-1:0] idx;
    logic                 sel_rst;
    logic                 unused_bits;

    assign idx         = addr[ADDR_W-1:2];
    assign sel_rst     = (idx == IDX_RST);
    assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:8]};

    always_comb begin
        r_d       = r_q;
        ready     = 1'b0;
        rdata     = '0;
        eng_start = 1'b0;
        eng_read  = 1'b0;

        if (r_q.rst_act) begin
            if (r_q.rst_cnt == '0) r_d.rst_act = 1'b0;
            else                   r_d.rst_cnt = r_q.rst_cnt - RC_W'(1);
        end

        if (req && !eng_busy && (!r_q.rst_act || sel_rst)) begin
            if (r_q.rd_pend) begin
                ready          = 1'b1;
                rdata[DQ_W-1:0] = rd_byte;
                r_d.rd_pend    = 1'b0;
            end else begin
                case (idx)
                    IDX_DATA: begin
                        if (wr) begin
                            ready     = 1'b1;
                            eng_start = r_q.mode.wen;
                        end else begin
                            eng_start   = 1'b1;
                            eng_read    = 1'b1;
                            r_d.rd_pend = 1'b1;
                        end
                    end
                    IDX_MODE: begin
                        ready    = 1'b1;
                        rdata[7] = r_q.mode.wen;
                        rdata[4] = r_q.mode.ce;
                        rdata[3:2] = r_q.mode.cs;
                        rdata[1] = r_q.mode.ale;
                        rdata[0] = r_q.mode.cle;
                        if (wr) begin
                            r_d.mode.wen = wdata[7];
                            r_d.mode.ce  = wdata[4];
                            r_d.mode.cs  = wdata[3:2];
                            r_d.mode.ale = wdata[1];
                            r_d.mode.cle = wdata[0];
                        end
                    end
                    IDX_STAT: begin
                        ready    = 1'b1;
                        rdata[7] = flash_busy;
                    end
                    IDX_TIME: begin
                        ready = 1'b1;
                        rdata[2*CNT_W-1:0] = {r_q.hold, r_q.spw};
                        if (wr) begin
                            r_d.hold = wdata[2*CNT_W-1:CNT_W];
                            r_d.spw  = wdata[CNT_W-1:0];
                        end
                    end
                    IDX_RST: begin
                        ready    = 1'b1;
                        rdata[0] = r_q.rst_act;
                        if (wr && wdata[0]) begin
                            r_d.rst_act = 1'b1;
                            r_d.rst_cnt = RC_W'(RST_CYCLES - 1);
                            r_d.mode    = '0;
                            r_d.spw     = DEF_SPW;
                            r_d.hold    = DEF_HOLD;
                        end
                    end
                    default: ready = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode    <= '0;
            r_q.spw     <= DEF_SPW;
            r_q.hold    <= DEF_HOLD;
            r_q.rst_act <= 1'b0;
            r_q.rst_cnt <= '0;
            r_q.rd_pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign eng_byte   = wdata[DQ_W-1:0];
    assign mode       = r_q.mode;
    assign spw        = r_q.spw;
    assign hold       = r_q.hold;
    assign rst_active = r_q.rst_act;
endmodule

// File: rtl/nfc_bus_ctrl.sv
`timescale 1ns/1ps
module nfc_bus_ctrl
    import nfc_pkg::*;
#(
    parameter int               DATA_W      = 32,
    parameter int               DQ_W        = 8,
    parameter int               CNT_W       = 4,
    parameter int               RST_CYCLES  = 3,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] DEF_SPW     = 4'd3,
    parameter logic [CNT_W-1:0] DEF_HOLD    = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [1:0]        nand_cs,
    output logic [DQ_W-1:0]   nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DQ_W-1:0]   nand_dq_in,
    input  logic              nand_rb_n
);
    logic             eng_busy, eng_start, eng_read;
    logic [DQ_W-1:0]  rd_byte, eng_byte;
    logic [CNT_W-1:0] spw, hold;
    logic             rb_sync, rst_active;
    mode_t            mode;

    nfc_rb_sync #(.STAGES(SYNC_STAGES)) i_rb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nand_rb_n),
        .sync_out (rb_sync)
    );

    nfc_regfile #(
        .DATA_W(DATA_W), .DQ_W(DQ_W), .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES),
        .DEF_SPW(DEF_SPW), .DEF_HOLD(DEF_HOLD)
    ) i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (bus_req),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .ready      (bus_ready),
        .rdata      (bus_rdata),
        .eng_busy   (eng_busy),
        .rd_byte    (rd_byte),
        .flash_busy (!rb_sync),
        .eng_start  (eng_start),
        .eng_read   (eng_read),
        .eng_byte   (eng_byte),
        .mode       (mode),
        .spw        (spw),
        .hold       (hold),
        .rst_active (rst_active)
    );

    nfc_strobe_engine #(.CNT_W(CNT_W), .DQ_W(DQ_W)) i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .is_read (eng_read),
        .wbyte   (eng_byte),
        .spw     (spw),
        .hold    (hold),
        .dq_in   (nand_dq_in),
        .busy    (eng_busy),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_out  (nand_dq_out),
        .dq_oe   (nand_dq_oe),
        .rd_byte (rd_byte)
    );

    assign nand_ce_n = !mode.ce;
    assign nand_cle  = mode.cle;
    assign nand_ale  = mode.ale;
    assign nand_cs   = mode.cs;
endmodule

// File: rtl/nfc_bus_ctrl_chk.sv
`timescale 1ns/1ps
module nfc_bus_ctrl_chk #(
    parameter int RST_CYCLES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_ce_n,
    input logic [1:0] nand_cs,
    input logic       rst_active
);
    logic [7:0] rst_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rst_run <= '0;
        else if (!rst_active)    rst_run <= '0;
        else if (rst_run != '1)  rst_run <= rst_run + 8'd1;
    end

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    a_r11_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> $stable({nand_cle, nand_ale, nand_ce_n, nand_cs}));

    a_r3_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);

    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    a_r3_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_dq_oe) |-> ($past(nand_we_n) && nand_we_n));

    a_r9_reset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rst_run <= 8'(RST_CYCLES));
endmodule

bind nfc_bus_ctrl nfc_bus_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_ce_n  (nand_ce_n),
    .nand_cs    (nand_cs),
    .rst_active (rst_active)
);

// File: tb/test_nfc_bus_ctrl.sv
`timescale 1ns/1ps
module test_nfc_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [1:0]  nand_cs;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb_n = 1'b1;

    int nvec = 0, nerr = 0;
    bit done = 0;
    int we_low = 0, re_low = 0, oe_cyc = 0, dq_bad = 0;
    logic [7:0] exp_dq = '0;

    always #2 clk = ~clk;

    nfc_bus_ctrl i_nfc_bus_ctrl (.*);

    always @(negedge clk) begin
        if (!nand_we_n) we_low <= we_low + 1;
        if (!nand_re_n) re_low <= re_low + 1;
        if (nand_dq_oe) oe_cyc <= oe_cyc + 1;
        if (!nand_we_n && nand_dq_out !== exp_dq) dq_bad <= dq_bad + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [4:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        waits = 0;
        #1;
        while (!bus_ready && waits < 1000) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic wreg(input logic [4:0] addr, input logic [31:0] wd);
        logic [31:0] rd; int w;
        access(1'b1, addr, wd, rd, w);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w, w0, r0, o0, b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ce_n", nand_ce_n, 1); check("R1 we_n", nand_we_n, 1);
        check("R1 re_n", nand_re_n, 1); check("R1 cle", nand_cle, 0);
        check("R1 ale", nand_ale, 0);   check("R1 oe", nand_dq_oe, 0);
        check("R1 cs", nand_cs, 0);
        access(0, 5'h04, 0, rd, w); check("R1 mode", rd, 0);
        access(0, 5'h14, 0, rd, w); check("R1 timing", rd, 32'h23);
        access(0, 5'h08, 0, rd, w); check("R1 status", rd, 0);
        access(0, 5'h18, 0, rd, w); check("R1 reset", rd, 0);

        // R2 mode register sweep
        for (int v = 0; v < 256; v++) begin
            wreg(5'h04, v);
            check("R2 ce_n", nand_ce_n, !v[4]); check("R2 cle", nand_cle, v[0]);
            check("R2 ale", nand_ale, v[1]);    check("R2 cs", nand_cs, v[3:2]);
            access(0, 5'h04, 0, rd, w); check("R2 readback", rd, v & 32'h9F);
        end

        // R3 / R6 / R7 write cycle timing sweep
        wreg(5'h04, 32'h91);
        for (int h = 0; h < 16; h++) begin
            for (int s = 0; s < 16; s++) begin
                wreg(5'h14, h * 16 + s);
                access(0, 5'h14, 0, rd, w); check("R7 timing readback", rd, h * 16 + s);
                exp_dq = 8'(h * 16 + s) ^ 8'hA5;
                w0 = we_low; r0 = re_low; o0 = oe_cyc; b0 = dq_bad;
                access(1, 5'h00, {24'hFFFFFF, exp_dq}, rd, w);
                check("R3 write waits", w, 0);
                access(0, 5'h08, 0, rd, w);
                check("R6 stall length", w, s + h + 3);
                check("R3 we_n low", we_low - w0, s + 1);
                check("R3 dq drive", oe_cyc - o0, s + h + 3);
                check("R3 dq value", dq_bad - b0, 0);
                check("R11 no re_n", re_low - r0, 0);
            end
        end

        // R4 write with write enable clear
        wreg(5'h04, 32'h10);
        w0 = we_low; o0 = oe_cyc;
        access(1, 5'h00, 32'h3C, rd, w); check("R4 waits", w, 0);
        access(0, 5'h08, 0, rd, w);      check("R4 no stall", w, 0);
        check("R4 no we_n", we_low - w0, 0); check("R4 no drive", oe_cyc - o0, 0);

        // R5 read cycle sweep
        for (int h = 0; h < 16; h++) begin
            for (int s = 0; s < 16; s++) begin
                wreg(5'h14, h * 16 + s);
                nand_dq_in = 8'(h * 16 + s) ^ 8'h3C;
                w0 = we_low; r0 = re_low; o0 = oe_cyc;
                access(0, 5'h00, 0, rd, w);
                check("R5 read data", rd, {24'h0, 8'(h * 16 + s) ^ 8'h3C});
                check("R5 read waits", w, s + h + 4);
                check("R5 re_n low", re_low - r0, s + 1);
                check("R5 no we_n", we_low - w0, 0);
                check("R5 no drive", oe_cyc - o0, 0);
            end
        end

        // R8 busy synchronizer
        @(negedge clk); nand_rb_n = 1'b0;
        access(0, 5'h08, 0, rd, w); check("R8 busy one edge", rd, 0);
        access(0, 5'h08, 0, rd, w); check("R8 busy two edges", rd, 32'h80);
        @(negedge clk); nand_rb_n = 1'b1;
        access(0, 5'h08, 0, rd, w); check("R8 ready one edge", rd, 32'h80);
        access(0, 5'h08, 0, rd, w); check("R8 ready two edges", rd, 0);

        // R9 soft reset
        wreg(5'h04, 32'h96); wreg(5'h14, 32'h7E);
        wreg(5'h18, 32'h1);
        access(0, 5'h18, 0, rd, w); check("R9 bit cycle 1", rd, 1);
        access(0, 5'h18, 0, rd, w); check("R9 bit cycle 2", rd, 1);
        access(0, 5'h18, 0, rd, w); check("R9 bit cycle 3", rd, 1);
        access(0, 5'h18, 0, rd, w); check("R9 bit cleared", rd, 0);
        access(0, 5'h04, 0, rd, w); check("R9 mode cleared", rd, 0);
        access(0, 5'h14, 0, rd, w); check("R9 timing default", rd, 32'h23);
        check("R9 ce_n high", nand_ce_n, 1);
        wreg(5'h04, 32'h10);
        wreg(5'h18, 32'h1);
        access(0, 5'h04, 0, rd, w);
        check("R9 stall waits", w, 3); check("R9 stalled mode", rd, 0);
        wreg(5'h04, 32'h10);
        wreg(5'h18, 32'h0);
        access(0, 5'h18, 0, rd, w); check("R9 write zero bit", rd, 0);
        access(0, 5'h04, 0, rd, w); check("R9 write zero mode", rd, 32'h10);

        // R10 reserved offsets
        wreg(5'h14, 32'h45);
        for (int k = 0; k < 3; k++) begin
            logic [4:0] a;
            a = (k == 0) ? 5'h0C : (k == 1) ? 5'h10 : 5'h1C;
            wreg(a, 32'hFFFFFFFF);
            access(0, a, 0, rd, w); check("R10 reads zero", rd, 0);
        end
        access(0, 5'h04, 0, rd, w); check("R10 mode kept", rd, 32'h10);
        access(0, 5'h14, 0, rd, w); check("R10 timing kept", rd, 32'h45);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule